// File: doc/BRIEF.md
# Bus Hold Arbiter with Refresh Preemption

This block decides when an external bus master may take the local bus and when the CPU gets it back. The request input arrives with no fixed timing relation to the block clock. It first passes through a synchronizer. The bus is then granted only at a point where the CPU is between bus cycles. Along with the acknowledge, the block raises a float enable. That enable turns off the address, data and control drivers. Chip-select drivers are not connected to it, so they stay driven during hold.

When the CPU no longer sees the request, it drops the acknowledge and the float enable. In the enhanced mode, a refresh that becomes pending while the bus is lent out is handled as follows. The acknowledge drops while the float enable stays on. The block then waits for the external master to release its request. Next it raises a refresh grant, so the internal refresh cycle can run on the driven bus. When the refresh done strobe arrives and the request is high again, the bus goes straight back to the master.

Top module: `bus_hold_arbiter`

## Requirements
- R1: After an active-low reset, holdAck, busFloat and refreshGrant are all 0.
- R2: holdReqAsync passes through a two-flop synchronizer. A rise of the request at idle shows on holdAck after the third rising clock edge, and not after the second.
- R3: A grant from the CPU-owned state happens only when busState is T4 (3'd4) or idle (3'd0). During T1 (3'd1), T2 (3'd2) and T3 (3'd3) the bus stays with the CPU.
- R4: busFloat rises in the same cycle as holdAck and is high whenever holdAck is high.
- R5: One cycle after the synchronized request is seen low while the bus is granted, holdAck and busFloat are both 0.
- R6: In enhanced mode (enhancedMode=1), refreshPending high while the bus is granted makes holdAck fall on the next edge. busFloat stays 1 until the synchronized request goes low.
- R7: After the request goes low in the preempted state, refreshGrant becomes 1 and busFloat becomes 0. holdAck and busFloat are never high together with refreshGrant.
- R8: refreshDone while refreshGrant is high and the synchronized request is high gives holdAck=1 and busFloat=1 one cycle later, whatever busState is.
- R9: Holding the request low for four clocks and then raising it again during a preemption gives exactly one refreshGrant period before the bus is handed back.
- R10: With enhancedMode=0, refreshPending has no effect while the bus is granted, and holdAck stays 1.
- R11: refreshDone while the synchronized request is low returns the bus to the CPU. A later request is then granted only at T4 or idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| holdReqAsync | input | 1 | External master bus request, asynchronous, active high |
| busState | input | 3 | CPU bus state: 0 idle, 1..4 T1..T4 |
| enhancedMode | input | 1 | 1 selects refresh-preempting behaviour |
| refreshPending | input | 1 | A memory refresh is waiting |
| refreshDone | input | 1 | One-cycle strobe: refresh cycle finished |
| holdAck | output | 1 | Bus granted to the external master |
| busFloat | output | 1 | Float enable for address, data and control drivers |
| refreshGrant | output | 1 | Internal refresh cycle may run |

## Verification
A request is raised while the CPU walks through T1 to T4. The grant must wait for T4, which separates a boundary-aware arbiter from one that grants as soon as the request arrives. A refresh pending is applied while the bus is granted, once in each mode. This shows that the preemption depends on the mode. The four-clock request drop is followed by a refresh done with the request already high again, which checks the immediate re-grant while busState shows a bus cycle. A second run finishes the refresh with the request still low, which separates a return to the CPU from a blind re-grant.

// File: rtl/bha_pkg.sv
package bha_pkg;

  localparam int BUS_STATE_W = 3;

  typedef enum logic [BUS_STATE_W-1:0] {
    BUS_IDLE = 3'd0,
    BUS_T1   = 3'd1,
    BUS_T2   = 3'd2,
    BUS_T3   = 3'd3,
    BUS_T4   = 3'd4
  } busState_e;

  typedef enum logic [1:0] {
    ST_CPU     = 2'd0,
    ST_GRANT   = 2'd1,
    ST_PREEMPT = 2'd2,
    ST_REFRESH = 2'd3
  } arbState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic ackSet;
    logic ackClr;
    logic floatSet;
    logic floatClr;
    logic rfshSet;
    logic rfshClr;
  } arbStrobe_t;

endpackage

// File: rtl/bha_datapath.sv
module bha_datapath
  import bha_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       holdReqAsync,
  input  arbStrobe_t stb,
  output logic       holdSync,
  output logic       holdAck,
  output logic       busFloat,
  output logic       refreshGrant
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] syncChain;

  generate
    if (SYNC_STAGES < 2) begin : g_bad
      initial $error("SYNC_STAGES must be at least 2");
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncChain <= '0;
    else       syncChain <= {syncChain[LAST-1:0], holdReqAsync};
  end

  assign holdSync = syncChain[LAST];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdAck      <= 1'b0;
      busFloat     <= 1'b0;
      refreshGrant <= 1'b0;
    end else begin
      if (stb.ackSet)        holdAck <= 1'b1;
      else if (stb.ackClr)   holdAck <= 1'b0;
      if (stb.floatSet)      busFloat <= 1'b1;
      else if (stb.floatClr) busFloat <= 1'b0;
      if (stb.rfshSet)       refreshGrant <= 1'b1;
      else if (stb.rfshClr)  refreshGrant <= 1'b0;
    end
  end

  // R4: the float enable never lags the acknowledge
  p_float_with_ack_r4: assert property (@(posedge clk) disable iff (!rstN)
    holdAck |-> busFloat);

  // R7: the refresh grant excludes both hold outputs
  p_grant_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    refreshGrant |-> (!busFloat && !holdAck));

endmodule

// File: rtl/bha_control.sv
module bha_control
  import bha_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   holdSync,
  input  logic [BUS_STATE_W-1:0] busState,
  input  logic                   enhancedMode,
  input  logic                   refreshPending,
  input  logic                   refreshDone,
  output arbStrobe_t             stb
);

  arbState_e state, nxt;
  logic atBoundary;

  assign atBoundary = (busState == BUS_T4) || (busState == BUS_IDLE);

  always_comb begin
    nxt = state;
    stb = '0;
    unique case (state)
      ST_CPU: begin
        if (holdSync && atBoundary) begin
          nxt = ST_GRANT;
          stb.ackSet = 1'b1;
          stb.floatSet = 1'b1;
        end
      end
      ST_GRANT: begin
        if (!holdSync) begin
          nxt = ST_CPU;
          stb.ackClr = 1'b1;
          stb.floatClr = 1'b1;
        end else if (enhancedMode && refreshPending) begin
          nxt = ST_PREEMPT;
          stb.ackClr = 1'b1;
        end
      end
      ST_PREEMPT: begin
        if (!holdSync) begin
          nxt = ST_REFRESH;
          stb.floatClr = 1'b1;
          stb.rfshSet = 1'b1;
        end
      end
      ST_REFRESH: begin
        if (refreshDone) begin
          stb.rfshClr = 1'b1;
          if (holdSync) begin
            nxt = ST_GRANT;
            stb.ackSet = 1'b1;
            stb.floatSet = 1'b1;
          end else begin
            nxt = ST_CPU;
          end
        end
      end
      default: nxt = ST_CPU;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_CPU;
    else       state <= nxt;
  end

  // R6: the preempted state holds while the master keeps its request
  p_wait_release_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PREEMPT && holdSync) |=> (state == ST_PREEMPT));

  // R3: leaving CPU ownership only at a cycle boundary
  p_cpu_leave_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CPU && !atBoundary) |=> (state == ST_CPU));

endmodule

// File: rtl/bus_hold_arbiter.sv
module bus_hold_arbiter
  import bha_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       holdReqAsync,
  input  logic [2:0] busState,
  input  logic       enhancedMode,
  input  logic       refreshPending,
  input  logic       refreshDone,
  output logic       holdAck,
  output logic       busFloat,
  output logic       refreshGrant
);

  arbStrobe_t stb;
  logic holdSync;

  bha_control u_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .holdSync       (holdSync),
    .busState       (busState),
    .enhancedMode   (enhancedMode),
    .refreshPending (refreshPending),
    .refreshDone    (refreshDone),
    .stb            (stb)
  );

  bha_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .holdReqAsync (holdReqAsync),
    .stb          (stb),
    .holdSync     (holdSync),
    .holdAck      (holdAck),
    .busFloat     (busFloat),
    .refreshGrant (refreshGrant)
  );

  // R3: a rising acknowledge follows T4, idle or a finished refresh
  p_ack_at_boundary_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdAck) |-> ($past(busState) == 3'd4 || $past(busState) == 3'd0
                        || $past(refreshGrant)));

  // R5: release once the synchronized request is low
  p_release_r5: assert property (@(posedge clk) disable iff (!rstN)
    (holdAck && !holdSync) |=> (!holdAck && !busFloat));

  // R10: plain mode keeps the grant regardless of refresh requests
  p_plain_ignores_r10: assert property (@(posedge clk) disable iff (!rstN)
    (holdAck && holdSync && !enhancedMode) |=> holdAck);

  // R6: enhanced preemption drops the acknowledge, keeps the float
  p_preempt_r6: assert property (@(posedge clk) disable iff (!rstN)
    (holdAck && holdSync && enhancedMode && refreshPending) |=> (!holdAck && busFloat));

  // R8: re-grant right after the refresh when the request is back
  p_regrant_r8: assert property (@(posedge clk) disable iff (!rstN)
    (refreshGrant && refreshDone && holdSync) |=> (holdAck && busFloat));

endmodule

// File: tb/tb_bus_hold_arbiter.sv
module tb_bus_hold_arbiter;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic holdReqAsync = 1'b0;
  logic [2:0] busState = 3'd0;
  logic enhancedMode = 1'b0;
  logic refreshPending = 1'b0;
  logic refreshDone = 1'b0;
  logic holdAck, busFloat, refreshGrant;

  int checks = 0;
  int errors = 0;
  int rgRises = 0;

  always #10 clk = ~clk; // 50 MHz

  bus_hold_arbiter dut (
    .clk (clk), .rstN (rstN), .holdReqAsync (holdReqAsync), .busState (busState),
    .enhancedMode (enhancedMode), .refreshPending (refreshPending),
    .refreshDone (refreshDone), .holdAck (holdAck), .busFloat (busFloat),
    .refreshGrant (refreshGrant)
  );

  always @(posedge refreshGrant) rgRises++;

  // vector: [9:7] busState, [6] enhanced, [5] hold, [4] refreshPending,
  // [3] refreshDone, [2:0] expected {ack, float, grant} before applying
  localparam int NV = 25;
  localparam logic [9:0] VEC [NV] = '{
    10'b001_0_1_0_0_000, 10'b010_0_1_0_0_000, 10'b011_0_1_0_0_000,
    10'b011_0_1_0_0_000, 10'b100_0_1_0_0_000, 10'b000_0_1_1_0_110,
    10'b000_0_1_1_0_110, 10'b000_0_0_0_0_110, 10'b000_0_0_0_0_110,
    10'b000_0_0_0_0_110, 10'b001_1_0_0_0_000, 10'b000_1_1_0_0_000,
    10'b000_1_1_0_0_000, 10'b000_1_1_0_0_000, 10'b000_1_1_1_0_110,
    10'b010_1_1_1_0_010, 10'b010_1_0_1_0_010, 10'b010_1_0_1_0_010,
    10'b010_1_0_1_0_010, 10'b010_1_0_1_0_001, 10'b010_1_1_1_0_001,
    10'b010_1_1_1_0_001, 10'b010_1_1_0_1_001, 10'b000_1_1_0_0_110,
    10'b000_1_1_0_0_110
  };

  function automatic string tagOf(int i);
    if (i <= 4)  return "R3";
    if (i <= 6)  return "R10";
    if (i <= 10) return "R5";
    if (i <= 14) return "R4";
    if (i <= 18) return "R6";
    if (i <= 22) return "R7";
    return "R8";
  endfunction

  task automatic chk(input string tag, input logic [2:0] exp);
    logic [2:0] act;
    act = {holdAck, busFloat, refreshGrant};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: ack/float/grant=%b expected %b", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (4000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    step(2);
    chk("R1", 3'b000);
    rstN = 1'b1;
    step(1);

    rgRises = 0;
    for (int i = 0; i < NV; i++) begin
      chk(tagOf(i), VEC[i][2:0]);
      busState = VEC[i][9:7];
      enhancedMode = VEC[i][6];
      holdReqAsync = VEC[i][5];
      refreshPending = VEC[i][4];
      refreshDone = VEC[i][3];
      step(1);
    end
    refreshDone = 1'b0;
    // R9: one refresh period for the four-clock request drop
    checks++;
    if (rgRises != 1) begin
      errors++;
      $display("FAIL R9: refresh grant periods=%0d expected 1", rgRises);
    end

    // R1: reset while granted clears everything
    rstN = 1'b0;
    step(1);
    chk("R1", 3'b000);
    holdReqAsync = 1'b0;
    busState = 3'd0;
    enhancedMode = 1'b1;
    step(1);
    rstN = 1'b1;
    step(1);

    // R2: three edges of latency through the synchronizer
    holdReqAsync = 1'b1;
    step(2);
    chk("R2", 3'b000);
    step(1);
    chk("R2", 3'b110);

    // R11: refresh ends with the request low, back to the CPU
    refreshPending = 1'b1;
    step(1);
    chk("R6", 3'b010);
    holdReqAsync = 1'b0;
    step(3);
    chk("R7", 3'b001);
    refreshPending = 1'b0;
    refreshDone = 1'b1;
    step(1);
    refreshDone = 1'b0;
    chk("R11", 3'b000);
    busState = 3'd2;
    holdReqAsync = 1'b1;
    step(5);
    chk("R11", 3'b000);
    busState = 3'd0;
    step(1);
    chk("R11", 3'b110);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule